// File: doc/BRIEF.md
# Transactional Undo/Redo Log Generator

This block sits next to a write-back, write-allocate data cache and records every word-sized store to persistent data made inside a transaction. For each captured store it reads the current contents of the target word from the cache just before the new data is merged. That value becomes the undo word and the store data becomes the redo word. Both words are packed with the word address and the current transaction number into one record. The record is appended to a fixed-size circular log through a write port that can stall. Opening and closing a transaction also produce marker records, so recovery can tell which updates belong together.

Requests arrive on one handshake channel with three operation kinds: store, begin and commit. A request is acknowledged only when its work is finished. For a request that produces a record, that means the log port has accepted it. On a cache miss the block asks the cache for a line fill and waits. It then repeats the lookup, so the undo word is always the filled value. Software reclaims the oldest log entries one at a time. The block refuses new requests while the log holds as many unreclaimed records as it has slots.

Top module: `undo_redo_logger`

## Requirements
- R1: After reset the log is empty and not full, the next log slot is index 0, and req_ready, log_valid, fill_req and cache_wr_en are all low.
- R2: A store (req_op 0) issued while a transaction is open emits exactly one record with the following fields. The type field is 2 (data) in bits [105:104]. The transaction number of the open transaction is in [103:96] and the word address in [95:64]. The undo word, equal to the cached value before the store, is in [63:32], and the store data is in [31:0].
- R3: When the lookup of a store misses, fill_req is raised for exactly one cycle and no record is emitted until fill_done. The lookup is then repeated, and the undo word is the value present after the fill.
- R4: The old word is read and the store data is written into the cache (cache_wr_en with cache_wr_data) in the same cycle, once per store. Back-to-back stores to one word therefore log the previous store's data as undo.
- R5: A begin (req_op 1) while no transaction is open emits a record with type 1, a new transaction number and zero address, undo and redo fields. Transaction numbers start at 0 after reset and rise by one per opened transaction.
- R6: A commit (req_op 2) while a transaction is open emits a record with type 3 carrying that transaction's number and zero other fields. It is emitted after all of that transaction's data records, and it closes the transaction.
- R7: A store while no transaction is open is still merged into the cache and acknowledged, but emits no record.
- R8: A begin while a transaction is open, a commit while none is open, and the unused code req_op 3 are each acknowledged with no record and no change to the transaction state.
- R9: For a request that produces a record, req_ready is high only in the cycle in which log_valid and log_ready are both high. While log_ready is low, log_valid stays high and log_record stays unchanged.
- R10: log_index is the slot of the next record. It starts at 0 and advances by one, modulo the log depth, for each accepted record. A log_reclaim pulse frees the oldest unreclaimed record and has no effect on an empty log.
- R11: log_full is high exactly when the log holds depth unreclaimed records. While it is high, no request is accepted: no lookup, no record and no req_ready. Service resumes after a reclaim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_ready | output | 1 | Request completed this cycle |
| req_op | input | 2 | 0 store, 1 begin, 2 commit, 3 unused |
| req_addr | input | 32 | Word address of a store |
| req_data | input | 32 | Store data (redo word) |
| cache_lookup | output | 1 | Cache read of the target word this cycle |
| cache_addr | output | 32 | Word address for lookup, fill and merge |
| cache_hit | input | 1 | Target line is resident |
| cache_rdata | input | 32 | Current cached word |
| cache_wr_en | output | 1 | Merge store data into the cached word |
| cache_wr_data | output | 32 | Data to merge |
| fill_req | output | 1 | One-cycle request for a write-allocate line fill |
| fill_done | input | 1 | Line fill finished |
| log_valid | output | 1 | Record offered to the log |
| log_ready | input | 1 | Log accepts the record |
| log_index | output | $clog2(LOG_DEPTH) | Circular slot of the offered record |
| log_record | output | 106 | Packed record: type, transaction, address, undo, redo |
| log_reclaim | input | 1 | Free the oldest unreclaimed record |
| log_full | output | 1 | No free log slot |

## Verification
The bench builds the block with a log depth of 8 instead of the default 16. This lets a short sequence of about ten records wrap the slot index, and lets a burst of eight unreclaimed records drive the log into the full state. The bench's cache model holds 64 words with a three-cycle fill delay, so both hit and miss paths occur. Log stalls of up to two cycles exercise the hold-and-acknowledge ordering.

// File: rtl/ulog_pkg.sv
package ulog_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int TXID_W = 8;
    localparam int KIND_W = 2;
    localparam int OP_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_STORE  = 2'd0,
        OP_BEGIN  = 2'd1,
        OP_COMMIT = 2'd2,
        OP_RSVD   = 2'd3
    } req_op_e;

    typedef enum logic [KIND_W-1:0] {
        REC_NONE   = 2'd0,
        REC_BEGIN  = 2'd1,
        REC_DATA   = 2'd2,
        REC_COMMIT = 2'd3
    } rec_kind_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_LOOKUP,
        CS_FILL,
        CS_EMIT,
        CS_ACK
    } cap_state_e;

    typedef struct packed {
        rec_kind_e         kind;
        logic [TXID_W-1:0] txid;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] undo_w;
        logic [WORD_W-1:0] redo_w;
    } log_rec_t;

    localparam int REC_W = $bits(log_rec_t);

    function automatic log_rec_t make_marker(input rec_kind_e kind,
                                             input logic [TXID_W-1:0] id);
        log_rec_t r;
        r      = '0;
        r.kind = kind;
        r.txid = id;
        return r;
    endfunction

    function automatic log_rec_t make_data(input logic [TXID_W-1:0] id,
                                           input logic [ADDR_W-1:0] a,
                                           input logic [WORD_W-1:0] redo);
        log_rec_t r;
        r        = '0;
        r.kind   = REC_DATA;
        r.txid   = id;
        r.addr   = a;
        r.redo_w = redo;
        return r;
    endfunction

endpackage

// File: rtl/ulog_ring.sv
module ulog_ring #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic                     reclaim,
    output logic [$clog2(DEPTH)-1:0] tail,
    output logic                     full
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count_q;
    logic             pop;

    assign pop  = reclaim && (count_q != '0);
    assign full = (count_q == CAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            tail    <= '0;
        end else begin
            if (push) begin
                tail <= (tail == LAST_IDX) ? '0 : tail + 1'b1;
            end
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R11: a record is never appended over an unreclaimed entry
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

endmodule

// File: rtl/ulog_txn.sv
module ulog_txn
    import ulog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_done,
    input  rec_kind_e         done_kind,
    output logic              txn_open,
    output logic [TXID_W-1:0] cur_id,
    output logic [TXID_W-1:0] next_id
);
    always_ff @(posedge clk) begin
        if (rst) begin
            txn_open <= 1'b0;
            cur_id   <= '0;
            next_id  <= '0;
        end else if (rec_done) begin
            case (done_kind)
                REC_BEGIN: begin
                    txn_open <= 1'b1;
                    cur_id   <= next_id;
                    next_id  <= next_id + 1'b1;
                end
                REC_COMMIT: txn_open <= 1'b0;
                default:    txn_open <= txn_open;
            endcase
        end
    end

    // R6: a commit marker only leaves while its transaction is open
    a_r6_commit_when_open: assert property (@(posedge clk) disable iff (rst)
        (rec_done && done_kind == REC_COMMIT) |-> txn_open);

    // R8: no second begin marker while a transaction is open
    a_r8_no_nested_begin: assert property (@(posedge clk) disable iff (rst)
        (rec_done && done_kind == REC_BEGIN) |-> !txn_open);

endmodule

// File: rtl/ulog_capture.sv
module ulog_capture
    import ulog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_data,
    output logic              req_ready,
    input  logic              space_ok,
    input  logic              txn_open,
    input  logic [TXID_W-1:0] cur_id,
    input  logic [TXID_W-1:0] next_id,
    output logic              cache_lookup,
    output logic [ADDR_W-1:0] cache_addr,
    input  logic              cache_hit,
    input  logic [WORD_W-1:0] cache_rdata,
    output logic              cache_wr_en,
    output logic [WORD_W-1:0] cache_wr_data,
    output logic              fill_req,
    input  logic              fill_done,
    output logic              log_valid,
    input  logic              log_ready,
    output log_rec_t          log_rec
);
    cap_state_e state_q;
    log_rec_t   rec_q;
    logic       logged_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CS_IDLE;
            rec_q    <= '0;
            logged_q <= 1'b0;
        end else begin
            case (state_q)
                CS_IDLE: begin
                    if (req_valid && space_ok) begin
                        case (req_op_e'(req_op))
                            OP_STORE: begin
                                rec_q    <= make_data(cur_id, req_addr, req_data);
                                logged_q <= txn_open;
                                state_q  <= CS_LOOKUP;
                            end
                            OP_BEGIN: begin
                                if (!txn_open) begin
                                    rec_q   <= make_marker(REC_BEGIN, next_id);
                                    state_q <= CS_EMIT;
                                end else begin
                                    state_q <= CS_ACK;
                                end
                            end
                            OP_COMMIT: begin
                                if (txn_open) begin
                                    rec_q   <= make_marker(REC_COMMIT, cur_id);
                                    state_q <= CS_EMIT;
                                end else begin
                                    state_q <= CS_ACK;
                                end
                            end
                            default: state_q <= CS_ACK;
                        endcase
                    end
                end
                CS_LOOKUP: begin
                    if (cache_hit) begin
                        rec_q.undo_w <= cache_rdata;
                        state_q      <= logged_q ? CS_EMIT : CS_ACK;
                    end else begin
                        state_q <= CS_FILL;
                    end
                end
                CS_FILL: begin
                    if (fill_done) begin
                        state_q <= CS_LOOKUP;
                    end
                end
                CS_EMIT: begin
                    if (log_ready) begin
                        state_q <= CS_IDLE;
                    end
                end
                CS_ACK:  state_q <= CS_IDLE;
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    assign cache_lookup  = (state_q == CS_LOOKUP);
    assign cache_addr    = rec_q.addr;
    assign cache_wr_en   = cache_lookup && cache_hit;
    assign cache_wr_data = rec_q.redo_w;
    assign fill_req      = cache_lookup && !cache_hit;
    assign log_valid     = (state_q == CS_EMIT);
    assign log_rec       = rec_q;
    assign req_ready     = (state_q == CS_ACK) || (log_valid && log_ready);

    // R3: one fill request per miss
    a_r3_fill_once: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> !fill_req);

    // R4: exactly one merge per store
    a_r4_single_merge: assert property (@(posedge clk) disable iff (rst)
        cache_wr_en |=> !cache_wr_en);

    // R9: a stalled record is held unchanged
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (log_valid && !log_ready) |=> (log_valid && $stable(log_rec)));

endmodule

// File: rtl/undo_redo_logger.sv
module undo_redo_logger
    import ulog_pkg::*;
#(
    parameter int LOG_DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [31:0]                  req_addr,
    input  logic [31:0]                  req_data,
    output logic                         cache_lookup,
    output logic [31:0]                  cache_addr,
    input  logic                         cache_hit,
    input  logic [31:0]                  cache_rdata,
    output logic                         cache_wr_en,
    output logic [31:0]                  cache_wr_data,
    output logic                         fill_req,
    input  logic                         fill_done,
    output logic                         log_valid,
    input  logic                         log_ready,
    output logic [$clog2(LOG_DEPTH)-1:0] log_index,
    output logic [105:0]                 log_record,
    input  logic                         log_reclaim,
    output logic                         log_full
);
    logic              txn_open;
    logic [TXID_W-1:0] cur_id;
    logic [TXID_W-1:0] next_id;
    logic              rec_push;
    log_rec_t          rec;

    assign rec_push   = log_valid && log_ready;
    assign log_record = rec;

    ulog_capture u_capture (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .req_ready     (req_ready),
        .space_ok      (!log_full),
        .txn_open      (txn_open),
        .cur_id        (cur_id),
        .next_id       (next_id),
        .cache_lookup  (cache_lookup),
        .cache_addr    (cache_addr),
        .cache_hit     (cache_hit),
        .cache_rdata   (cache_rdata),
        .cache_wr_en   (cache_wr_en),
        .cache_wr_data (cache_wr_data),
        .fill_req      (fill_req),
        .fill_done     (fill_done),
        .log_valid     (log_valid),
        .log_ready     (log_ready),
        .log_rec       (rec)
    );

    ulog_txn u_txn (
        .clk       (clk),
        .rst       (rst),
        .rec_done  (rec_push),
        .done_kind (rec.kind),
        .txn_open  (txn_open),
        .cur_id    (cur_id),
        .next_id   (next_id)
    );

    ulog_ring #(.DEPTH(LOG_DEPTH)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .push    (rec_push),
        .reclaim (log_reclaim),
        .tail    (log_index),
        .full    (log_full)
    );

    // R7: data records only leave while a transaction is open
    a_r7_data_inside_txn: assert property (@(posedge clk) disable iff (rst)
        (log_valid && rec.kind == REC_DATA) |-> txn_open);

    // R11: nothing is looked up while the log is full
    a_r11_idle_when_full: assert property (@(posedge clk) disable iff (rst)
        log_full |-> !cache_lookup);

endmodule

// File: tb/test_undo_redo_logger.sv
module test_undo_redo_logger;
    import ulog_pkg::*;

    localparam int DEPTH = 8;
    localparam int NV    = 16;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  stall;
        logic        rec;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h05, 32'h1111_0001, 2'd0, 1'b0},
        '{2'd2, 32'h00, 32'h0,         2'd0, 1'b0},
        '{2'd1, 32'h00, 32'h0,         2'd0, 1'b1},
        '{2'd0, 32'h05, 32'hA5A5_0002, 2'd1, 1'b1},
        '{2'd0, 32'h05, 32'hA5A5_0003, 2'd0, 1'b1},
        '{2'd0, 32'h09, 32'h0000_0009, 2'd2, 1'b1},
        '{2'd1, 32'h00, 32'h0,         2'd0, 1'b0},
        '{2'd0, 32'h3F, 32'hDEAD_BEEF, 2'd0, 1'b1},
        '{2'd3, 32'h07, 32'h7777_7777, 2'd0, 1'b0},
        '{2'd2, 32'h00, 32'h0,         2'd1, 1'b1},
        '{2'd0, 32'h09, 32'h1234_5678, 2'd0, 1'b0},
        '{2'd1, 32'h00, 32'h0,         2'd0, 1'b1},
        '{2'd0, 32'h09, 32'hCAFE_F00D, 2'd1, 1'b1},
        '{2'd0, 32'h00, 32'h0BAD_0000, 2'd0, 1'b1},
        '{2'd2, 32'h00, 32'h0,         2'd2, 1'b1},
        '{2'd2, 32'h00, 32'h0,         2'd0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_op = 2'd0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_data = '0;
    logic         cache_lookup;
    logic [31:0]  cache_addr;
    logic         cache_hit;
    logic [31:0]  cache_rdata;
    logic         cache_wr_en;
    logic [31:0]  cache_wr_data;
    logic         fill_req;
    logic         fill_done;
    logic         log_valid;
    logic         log_ready = 1'b0;
    logic [2:0]   log_index;
    logic [105:0] log_record;
    logic         log_reclaim = 1'b0;
    logic         log_full;

    int errors = 0;
    int checks = 0;
    int occ = 0;
    int exp_tail = 0;
    bit finished = 0;

    logic [31:0] ref_mem [64];
    logic [63:0] ref_present = '0;
    bit          ref_open = 0;
    logic [7:0]  ref_cur = '0;
    logic [7:0]  ref_next = '0;

    always #2.5 clk = ~clk;

    undo_redo_logger #(.LOG_DEPTH(DEPTH)) i_undo_redo_logger (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .cache_lookup  (cache_lookup),
        .cache_addr    (cache_addr),
        .cache_hit     (cache_hit),
        .cache_rdata   (cache_rdata),
        .cache_wr_en   (cache_wr_en),
        .cache_wr_data (cache_wr_data),
        .fill_req      (fill_req),
        .fill_done     (fill_done),
        .log_valid     (log_valid),
        .log_ready     (log_ready),
        .log_index     (log_index),
        .log_record    (log_record),
        .log_reclaim   (log_reclaim),
        .log_full      (log_full)
    );

    // Cache contents model: 64 words, three-cycle write-allocate fill
    logic [31:0] cmem [64];
    logic [63:0] present;
    logic        fill_busy;
    logic [1:0]  fill_cnt;
    logic [5:0]  fill_idx;

    function automatic logic [31:0] fillval(input logic [5:0] i);
        return 32'h5EED_0000 ^ {26'd0, i};
    endfunction

    assign cache_hit   = present[cache_addr[5:0]];
    assign cache_rdata = cmem[cache_addr[5:0]];

    always @(posedge clk) begin
        fill_done <= 1'b0;
        if (rst) begin
            present   <= '0;
            fill_busy <= 1'b0;
            fill_cnt  <= '0;
            fill_idx  <= '0;
            for (int i = 0; i < 64; i++) cmem[i] <= '0;
        end else begin
            if (cache_wr_en) cmem[cache_addr[5:0]] <= cache_wr_data;
            if (fill_req) begin
                fill_busy <= 1'b1;
                fill_cnt  <= 2'd2;
                fill_idx  <= cache_addr[5:0];
            end else if (fill_busy) begin
                if (fill_cnt == 2'd0) begin
                    cmem[fill_idx]    <= fillval(fill_idx);
                    present[fill_idx] <= 1'b1;
                    fill_done         <= 1'b1;
                    fill_busy         <= 1'b0;
                end else begin
                    fill_cnt <= fill_cnt - 1'b1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] d, input int stall, input bit exp_rec);
        log_rec_t    expr, got, first;
        bit          have_exp, miss, saw_fill, saw_rec, seen_valid, done;
        int          waitc, guard;
        logic [31:0] old;
        string       tag;
        have_exp = 0; miss = 0; saw_fill = 0; saw_rec = 0; seen_valid = 0; done = 0;
        waitc = 0; guard = 0; old = '0; expr = '0; got = '0; first = '0;
        tag = "R8";
        case (op)
            2'd0: begin
                miss = !ref_present[a[5:0]];
                if (miss) begin
                    ref_mem[a[5:0]]     = fillval(a[5:0]);
                    ref_present[a[5:0]] = 1'b1;
                end
                old = ref_mem[a[5:0]];
                ref_mem[a[5:0]] = d;
                tag = ref_open ? (miss ? "R3" : "R2") : "R7";
                if (ref_open) begin
                    have_exp = 1;
                    expr = '{REC_DATA, ref_cur, a, old, d};
                end
            end
            2'd1: if (!ref_open) begin
                have_exp = 1; tag = "R5";
                expr = '{REC_BEGIN, ref_next, 32'd0, 32'd0, 32'd0};
            end
            2'd2: if (ref_open) begin
                have_exp = 1; tag = "R6";
                expr = '{REC_COMMIT, ref_cur, 32'd0, 32'd0, 32'd0};
            end
            default: tag = "R8";
        endcase

        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        log_ready = (stall == 0);
        while (!done) begin
            #1;
            if (fill_req) saw_fill = 1;
            if (log_valid) begin
                got = log_rec_t'(log_record);
                if (!seen_valid) begin
                    first = got; seen_valid = 1;
                end else begin
                    chk(got == first, "R9", "record held while stalled", got, first);
                end
                if (!log_ready) begin
                    chk(!req_ready, "R9", "ack before log accepted", req_ready, 0);
                    waitc++;
                end else begin
                    saw_rec = 1;
                    chk(got == expr, tag, "record contents", got, expr);
                    chk(log_index == exp_tail[2:0], "R10", "log slot", log_index, exp_tail);
                    occ++;
                    exp_tail = (exp_tail + 1) % DEPTH;
                end
            end
            if (req_ready) done = 1;
            guard++;
            if (guard > 200) begin
                chk(0, tag, "request never acknowledged", 0, 1);
                done = 1;
            end
            @(negedge clk);
            log_ready = (waitc >= stall);
        end
        req_valid = 1'b0;
        log_ready = 1'b0;

        if (have_exp && op == 2'd1) begin
            ref_open = 1; ref_cur = ref_next; ref_next = ref_next + 1'b1;
        end
        if (have_exp && op == 2'd2) ref_open = 0;

        chk(saw_rec == exp_rec, tag, "record emitted", saw_rec, exp_rec);
        if (op == 2'd0) begin
            chk(saw_fill == miss, "R3", "fill request on miss only", saw_fill, miss);
            chk(cmem[a[5:0]] == d, "R4", "store merged into cache", cmem[a[5:0]], d);
        end
        chk(log_full == (occ == DEPTH), "R11", "full flag", log_full, occ == DEPTH);
    endtask

    task automatic reclaim_one();
        log_reclaim = 1'b1;
        @(negedge clk);
        log_reclaim = 1'b0;
        if (occ > 0) occ--;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(!log_full, "R1", "log_full after reset", log_full, 0);
        chk(!log_valid, "R1", "log_valid after reset", log_valid, 0);
        chk(!req_ready, "R1", "req_ready after reset", req_ready, 0);
        chk(log_index == 3'd0, "R1", "log_index after reset", log_index, 0);
        chk(!fill_req && !cache_wr_en, "R1", "cache strobes after reset",
            {fill_req, cache_wr_en}, 0);

        // Table walk: hits, misses, nesting, ignored codes, stalls, wrap
        for (int v = 0; v < NV; v++) begin
            run_op(VECS[v].op, VECS[v].addr, VECS[v].data, int'(VECS[v].stall), VECS[v].rec);
            if (occ > 0) reclaim_one();
        end

        // R10: reclaim on an empty log has no effect
        reclaim_one();
        #1;
        chk(!log_full && log_index == exp_tail[2:0], "R10", "reclaim when empty",
            log_index, exp_tail);

        // R11: fill the log without reclaiming
        run_op(2'd1, 32'h0, 32'h0, 0, 1'b1);
        for (int k = 0; k < DEPTH - 1; k++) begin
            run_op(2'd0, 32'h05, 32'h4000_0000 + k, 0, 1'b1);
        end
        #1;
        chk(log_full, "R11", "full after depth records", log_full, 1);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2; req_addr = '0; req_data = '0; log_ready = 1'b1;
        for (int k = 0; k < 6; k++) begin
            #1;
            chk(!req_ready && !cache_lookup && !log_valid, "R11", "request blocked while full",
                {req_ready, cache_lookup, log_valid}, 0);
            @(negedge clk);
        end
        req_valid = 1'b0; log_ready = 1'b0;
        reclaim_one();
        #1;
        chk(!log_full, "R11", "full clears after reclaim", log_full, 0);
        run_op(2'd2, 32'h0, 32'h0, 0, 1'b1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule